// File: doc/BRIEF.md
# Periodic Interval Trigger Timer

This block produces the time base that starts conversion sequences in a queued analog-to-digital converter sequencer with two command queues. A free-running counter runs while at least one queue is programmed to a timer-driven operating mode. Each time the counter reaches the end of the selected interval, it returns to zero and emits a one-cycle strobe. Each queue then receives its own trigger pulse, gated by that queue's mode.

The counter is held at zero, or briefly restarted, by a set of rules that treat the two queues differently:
- A mode change on the first queue always restarts the interval.
- A mode change on the second queue restarts it only when the first queue is not using the timer.
- Stop and debug levels hold the counter at zero. After stop, a queue must have its mode rewritten before it counts as using the timer again.
- A freeze request restarts the count only once the conversion in progress has ended.

The single-scan mode delivers exactly one trigger per arming.

Top module: `pit_trigger_timer`

## Requirements
- R1: While `rst_n` is low, `roll_o`, `q1_trig_o` and `q2_trig_o` are 0 and the counter is cleared.
- R2: The roll-over interval is P = 2^(BASE_LOG + min(`period_sel_i`, MAX_SEL)) clock cycles (defaults BASE_LOG=7, MAX_SEL=10). `roll_o` is high for exactly one cycle per interval, and a continuously running counter produces one `roll_o` every P cycles.
- R3: A queue uses the timer when its 4-bit mode code is 5 (periodic continuous), or when its mode code is 4 (interval single-scan) and its single-scan enable is 1. Every other code is a non-timer mode. While neither queue uses the timer, the counter stays at zero and `roll_o` stays 0.
- R4: While `stop_i` or `debug_i` is 1, the counter is held at zero and no output pulses. After release, the first `roll_o` comes P cycles later.
- R5: When queue 1 enters a timer mode or switches to a different timer mode, the counter restarts from zero. This happens even if queue 2 is already using the timer, and the next `roll_o` comes P+1 cycles after the new mode is presented.
- R6: When queue 2 enters a timer mode, the counter restarts only if queue 1 is not using the timer at that time. Otherwise the count in progress continues undisturbed.
- R7: A queue's trigger output is high only in a cycle where `roll_o` is high. In mode 5 it is high on every `roll_o`.
- R8: In single-scan mode, setting the enable arms the queue. Only the first `roll_o` after arming raises that queue's trigger. Later roll-overs do not raise it until the queue is re-armed.
- R9: After `stop_i` has been high, a queue does not use the timer until its mode input has shown a non-timer code and then a timer code again.
- R10: A freeze request while the timer runs is latched. The counter restarts on the first edge at which `conv_busy_i` is 0, exactly once even if freeze was already released. While freeze stays high with no conversion busy, the counter stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_i | input | 1 | Stop-mode level |
| debug_i | input | 1 | Debug-mode level |
| freeze_i | input | 1 | Freeze request |
| conv_busy_i | input | 1 | A conversion is in progress |
| q1_mode_i | input | 4 | Queue 1 operating-mode code |
| q1_ss_en_i | input | 1 | Queue 1 single-scan enable |
| q2_mode_i | input | 4 | Queue 2 operating-mode code |
| q2_ss_en_i | input | 1 | Queue 2 single-scan enable |
| period_sel_i | input | 4 | Interval length select |
| roll_o | output | 1 | One-cycle roll-over strobe |
| q1_trig_o | output | 1 | Queue 1 trigger |
| q2_trig_o | output | 1 | Queue 2 trigger |

## Verification
The bench uses a reduced configuration (BASE_LOG=3, MAX_SEL=4) and covers the following patterns:
- It sweeps all sixteen period selects, measuring both the latency after a mode write and the steady period. This separates the clamp above MAX_SEL from the exponent arithmetic.
- It sweeps all sixteen mode codes on queue 1, with and without single-scan enable. This shows that only codes 5 and enabled 4 start the counter.
- It presents mode changes mid-interval on each queue with the other queue idle or running. The measured distance to the next roll-over (P+1 versus the remaining P-k) tells a restart apart from an undisturbed count.
- It runs stop, debug and freeze sequences against busy and idle conversions. Here the distance to the next roll-over separates hold, single deferred restart and no restart.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int MODE_W = 4;
  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t MODE_SINGLE = mode_t'(4);
  localparam mode_t MODE_CONT   = mode_t'(5);

  function automatic logic is_timer_code(mode_t m);
    return (m == MODE_SINGLE) || (m == MODE_CONT);
  endfunction
endpackage

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int BASE_LOG = 7,
  parameter int MAX_SEL  = 10,
  parameter int SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             roll_o
);
  localparam int CNT_W = BASE_LOG + MAX_SEL;
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(MAX_SEL);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [SEL_W-1:0] sel_c;
  logic [CNT_W-1:0] lim, cnt_q, cnt_n;
  logic             at_lim, cnt_en;

  always_comb begin
    sel_c  = (sel_i > SEL_MAX) ? SEL_MAX : sel_i;
    lim    = ALL_ONES >> (SEL_MAX - sel_c);
    at_lim = (cnt_q == lim);
    roll_o = !hold_i && !clear_i && at_lim;
    cnt_en = !(hold_i && (cnt_q == '0));
    cnt_n  = (hold_i || clear_i || at_lim) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R4 / R3: a held counter reads zero on the next cycle
  p_hold_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0));
  // R2: every roll-over returns the count to zero
  p_roll_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |=> (cnt_q == '0));
endmodule

// File: rtl/pit_queue_qual.sv
module pit_queue_qual
  import pit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stop_i,
  input  mode_t mode_i,
  input  logic  ss_en_i,
  input  logic  roll_i,
  output logic  use_o,
  output logic  enter_o,
  output logic  trig_o
);
  logic  lock_q, lock_n;
  logic  use_q, ss_act_q, armed_q, armed_n, trig_q, trig_n;
  mode_t mode_q;
  logic  ss_act;

  always_comb begin
    lock_n  = stop_i || (lock_q && is_timer_code(mode_i));
    ss_act  = !lock_q && !stop_i && (mode_i == MODE_SINGLE) && ss_en_i;
    use_o   = ss_act || (!lock_q && !stop_i && (mode_i == MODE_CONT));
    enter_o = use_o && (!use_q || (mode_i != mode_q));
    if (!ss_act)        armed_n = 1'b0;
    else if (!ss_act_q) armed_n = 1'b1;
    else                armed_n = armed_q && !roll_i;
    trig_n  = roll_i && ((use_o && (mode_i == MODE_CONT)) || (ss_act && armed_q));
    trig_o  = trig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      use_q    <= 1'b0;
      mode_q   <= '0;
      ss_act_q <= 1'b0;
      armed_q  <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      lock_q   <= lock_n;
      use_q    <= use_o;
      mode_q   <= mode_i;
      ss_act_q <= ss_act;
      armed_q  <= armed_n;
      trig_q   <= trig_n;
    end
  end

  // R9: right after stop drops the queue is still locked out
  p_lock_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_i) |-> !use_o);
  // R8: a single-scan trigger leaves the queue disarmed
  p_single_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && (mode_q == MODE_SINGLE)) |-> !armed_q);
endmodule

// File: rtl/pit_trigger_timer.sv
module pit_trigger_timer
  import pit_pkg::*;
#(
  parameter int BASE_LOG = 7,
  parameter int MAX_SEL  = 10,
  parameter int SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             debug_i,
  input  logic             freeze_i,
  input  logic             conv_busy_i,
  input  logic [3:0]       q1_mode_i,
  input  logic             q1_ss_en_i,
  input  logic [3:0]       q2_mode_i,
  input  logic             q2_ss_en_i,
  input  logic [SEL_W-1:0] period_sel_i,
  output logic             roll_o,
  output logic             q1_trig_o,
  output logic             q2_trig_o
);
  localparam int NQ = 2;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  mode_t         mode_a [NQ];
  logic [NQ-1:0] ss_a, use_a, enter_a, trig_a;
  logic          any_use, hold, restart, frz_fire, clear, roll_c;
  logic          frz_pend_q, frz_pend_n, roll_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    mode_a[0] = q1_mode_i;
    mode_a[1] = q2_mode_i;
    ss_a      = {q2_ss_en_i, q1_ss_en_i};
  end

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    pit_queue_qual u_qual (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .stop_i  (stop_i),
      .mode_i  (mode_a[g]),
      .ss_en_i (ss_a[g]),
      .roll_i  (roll_c),
      .use_o   (use_a[g]),
      .enter_o (enter_a[g]),
      .trig_o  (trig_a[g])
    );
  end

  always_comb begin
    any_use    = |use_a;
    hold       = stop_i || debug_i || !any_use;
    restart    = enter_a[0] || (enter_a[1] && !use_a[0]);
    frz_fire   = frz_pend_q && !conv_busy_i;
    clear      = restart || frz_fire;
    frz_pend_n = !hold && (freeze_i || (frz_pend_q && !frz_fire));
  end

  pit_counter #(.BASE_LOG(BASE_LOG), .MAX_SEL(MAX_SEL), .SEL_W(SEL_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hold_i  (hold),
    .clear_i (clear),
    .sel_i   (period_sel_i),
    .roll_o  (roll_c)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      frz_pend_q <= 1'b0;
      roll_q     <= 1'b0;
    end else begin
      frz_pend_q <= frz_pend_n;
      roll_q     <= roll_c;
    end
  end

  assign roll_o    = roll_q;
  assign q1_trig_o = trig_a[0];
  assign q2_trig_o = trig_a[1];

  // R2: the strobe never lasts two cycles
  p_roll_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    roll_o |=> !roll_o);
  // R7: queue triggers only coincide with roll-over
  p_trig_with_roll_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (q1_trig_o || q2_trig_o) |-> roll_o);
  // R4: stop or debug silences the next strobe
  p_quiet_in_stop_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop_i || debug_i) |=> !roll_o);
  // R10: a pending freeze waits while the conversion is busy
  p_freeze_waits_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frz_pend_q && conv_busy_i && !hold) |=> frz_pend_q);
endmodule

// File: tb/test_pit_trigger_timer.sv
`timescale 1ns/1ps
module test_pit_trigger_timer;
  localparam int BL = 3;
  localparam int MS = 4;

  logic clk = 1'b0;
  logic rst_n, stop_i, debug_i, freeze_i, busy;
  logic [3:0] m1, m2, sel;
  logic ss1, ss2;
  logic roll_o, q1_trig_o, q2_trig_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pit_trigger_timer #(.BASE_LOG(BL), .MAX_SEL(MS), .SEL_W(4)) i_pit_trigger_timer (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .debug_i(debug_i),
    .freeze_i(freeze_i), .conv_busy_i(busy),
    .q1_mode_i(m1), .q1_ss_en_i(ss1), .q2_mode_i(m2), .q2_ss_en_i(ss2),
    .period_sel_i(sel), .roll_o(roll_o), .q1_trig_o(q1_trig_o), .q2_trig_o(q2_trig_o));

  function automatic int per(int s);
    return 1 << (BL + ((s > MS) ? MS : s));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // counts edges until roll_o is seen high, giving up at lim
  task automatic wait_roll(output int n, input int lim);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!roll_o && n < lim);
  endtask

  task automatic idle_all();
    m1 = 0; m2 = 0; ss1 = 0; ss2 = 0;
    stop_i = 0; debug_i = 0; freeze_i = 0; busy = 0;
    edges(2);
  endtask

  initial begin
    int n, p;
    rst_n = 0; stop_i = 0; debug_i = 0; freeze_i = 0; busy = 0;
    m1 = 5; m2 = 5; ss1 = 1; ss2 = 1; sel = 0;
    edges(3);
    chk(roll_o == 0 && q1_trig_o == 0 && q2_trig_o == 0, "R1 outputs in reset",
        {roll_o, q1_trig_o, q2_trig_o}, 0);
    m1 = 0; m2 = 0; ss1 = 0; ss2 = 0;
    rst_n = 1;
    edges(4);

    // R2 period sweep including clamp above MAX_SEL
    for (int s = 0; s < 16; s++) begin
      idle_all();
      sel = s[3:0]; p = per(s);
      m1 = 5;
      wait_roll(n, 2 * p + 4);
      chk(n == p + 1, "R2 latency", n, p + 1);
      edges(1);
      chk(roll_o == 0, "R2 strobe width", roll_o, 0);
      wait_roll(n, 2 * p + 4);
      chk(n == p - 1, "R2 period", n + 1, p);
    end

    // R3 mode code sweep on queue 1
    sel = 0; p = per(0);
    for (int ss = 0; ss < 2; ss++) begin
      for (int m = 0; m < 16; m++) begin
        idle_all();
        ss1 = ss[0]; m1 = m[3:0];
        wait_roll(n, 2 * p + 2);
        if (m == 5 || (m == 4 && ss == 1))
          chk(n == p + 1, "R3 timer code starts counter", n, p + 1);
        else
          chk(roll_o == 0, "R3 non-timer code holds counter", roll_o, 0);
      end
    end

    // R7 per-queue qualification
    idle_all(); sel = 1; p = per(1);
    m1 = 5;
    wait_roll(n, 2 * p);
    chk(q1_trig_o == 1 && q2_trig_o == 0, "R7 only q1 triggers",
        {q1_trig_o, q2_trig_o}, 2);

    // R6 q2 entry ignored while q1 runs
    edges(5);
    m2 = 5;
    wait_roll(n, 2 * p);
    chk(n == p - 5, "R6 q2 entry no restart", n, p - 5);
    chk(q1_trig_o == 1 && q2_trig_o == 1, "R7 both trigger",
        {q1_trig_o, q2_trig_o}, 3);

    // R5 q1 entry restarts although q2 runs
    m1 = 0;
    wait_roll(n, 2 * p);
    edges(5);
    m1 = 5;
    wait_roll(n, 2 * p);
    chk(n == p + 1, "R5 q1 entry restarts", n, p + 1);

    // R5 switch between timer modes on q1
    edges(5);
    ss1 = 1; m1 = 4;
    wait_roll(n, 2 * p);
    chk(n == p + 1, "R5 q1 mode switch restarts", n, p + 1);

    // R6 q2 entry restarts when q1 idle
    idle_all();
    m2 = 5;
    wait_roll(n, 2 * p);
    edges(5);
    ss2 = 1; m2 = 4;
    wait_roll(n, 2 * p);
    chk(n == p + 1, "R6 q2 entry restarts with q1 idle", n, p + 1);

    // R8 single-scan fires once per arming
    idle_all();
    m1 = 5; m2 = 4; ss2 = 0;
    wait_roll(n, 2 * p);
    chk(q2_trig_o == 0, "R8 no trigger while disabled", q2_trig_o, 0);
    ss2 = 1;
    wait_roll(n, 2 * p);
    chk(q2_trig_o == 1, "R8 first roll after arming", q2_trig_o, 1);
    wait_roll(n, 2 * p);
    chk(roll_o == 1 && q2_trig_o == 0, "R8 later roll silent", {roll_o, q2_trig_o}, 2);

    // R4 debug holds, restarts from zero
    idle_all();
    m1 = 5;
    wait_roll(n, 2 * p);
    edges(3);
    debug_i = 1;
    wait_roll(n, 2 * p + 2);
    chk(roll_o == 0, "R4 debug holds", roll_o, 0);
    debug_i = 0;
    wait_roll(n, 2 * p);
    chk(n == p, "R4 count after debug", n, p);

    // R9 stop lock until rewrite
    stop_i = 1;
    edges(3);
    stop_i = 0;
    wait_roll(n, 2 * p + 2);
    chk(roll_o == 0, "R9 locked after stop", roll_o, 0);
    m1 = 0; edges(1);
    m1 = 5;
    wait_roll(n, 2 * p);
    chk(n == p + 1, "R9 rewrite releases", n, p + 1);

    // R10 freeze pulse during busy conversion
    sel = 2; p = per(2);
    busy = 1;
    m1 = 0; edges(1); m1 = 5;
    wait_roll(n, 2 * p);
    edges(2);
    freeze_i = 1; edges(1); freeze_i = 0;
    edges(3);
    busy = 0;
    wait_roll(n, 2 * p);
    chk(n == p + 1, "R10 deferred restart", n, p + 1);
    wait_roll(n, 2 * p);
    chk(n == p, "R10 single restart", n, p);

    // R10 freeze held while idle
    freeze_i = 1;
    wait_roll(n, 3 * p);
    chk(roll_o == 0, "R10 freeze idle holds", roll_o, 0);
    freeze_i = 0;
    wait_roll(n, 2 * p);
    chk(n == p + 1, "R10 release count", n, p + 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule